// File: doc/BRIEF.md
# Banked Register Address Decoder for a Two-Channel Serial Port

This block sits between a host bus and two serial channels. A host access carries an active-low chip select, a channel line, a 3-bit register address and separate read and write strobes. The block turns that access into a channel enable and a one-hot register select. It drives write strobes for the registers that live in other blocks (transmit holding, interrupt enable, FIFO control, modem control). It also returns one registered read byte per read.

Three register banks overlay the same eight addresses. The line control register of the addressed channel picks the bank. When its top bit is clear, the general bank applies. When its top bit is set, the divisor latch bytes replace addresses 0 and 1. When the register holds exactly 0xBF, the flow-control bank applies. Several general addresses name one register for reads and another for writes, and two of them can only be read.

This block stores, for each channel, the line control byte, the scratch byte, the 16-bit baud divisor, the feature byte and the four flow-control character bytes. It publishes them as outputs for the rest of the channel. The receive, transmit, FIFO and interrupt machinery stays outside. That machinery is reached only through the strobes and the external read-data inputs.

Top module: `dual_uart_regdec`

## Requirements
- R1: With `cs_n` high, `chan_en` is zero and no select or strobe is raised. With `cs_n` low, `chan_en` has exactly bit `chan_sel` set, in the same cycle.
- R2: `reg_sel` bit positions are: 0 receive holding, 1 transmit holding, 2 interrupt enable, 3 interrupt status, 4 FIFO control, 5 line control, 6 modem control, 7 line status, 8 modem status, 9 scratch, 10 divisor low, 11 divisor high, 12 feature, 13 xon1, 14 xon2, 15 xoff1, 16 xoff2. With the selected channel's line control bit 7 clear, the addresses map as follows:
  - 0: bit 0 on read, bit 1 on write
  - 1: bit 2
  - 2: bit 3 on read, bit 4 on write
  - 3: bit 5
  - 4: bit 6
  - 5: bit 7
  - 6: bit 8
  - 7: bit 9
- R3: With line control bit 7 set and the value not 0xBF, address 0 selects divisor low and address 1 selects divisor high. Addresses 2 to 7 keep their general-bank meaning.
- R4: With line control exactly 0xBF, the addresses map as follows:
  - 2: feature
  - 4: xon1
  - 5: xon2
  - 6: xoff1
  - 7: xoff2
  - 0: divisor low
  - 1: divisor high
  - 3: line control
- R5: A write to address 5 or 6 outside the 0xBF bank selects nothing, raises no strobe and changes no stored register.
- R6: Each channel keeps its own copy of every stored register. A write changes only the addressed channel's copy, and the bank is taken from that channel's own line control byte.
- R7: After reset every stored register is zero except the divisor, which is 1. `rd_data` is 0 and `rd_valid` is 0.
- R8: A read returns the selected register on `rd_data`, with `rd_valid` high for one cycle, on the clock edge after the read strobe. `rd_data` holds its value otherwise.
- R9: A read of receive holding raises bit `chan_sel` of `rhr_pop` for exactly one cycle, aligned with `rd_valid`.
- R10: `thr_we`, `ier_we`, `fcr_we` and `mcr_we` are raised combinationally, only for the addressed channel, during a write to that register. A stored register takes `wdata` at the clock edge of its write.
- R11: An access with `rd_en` and `wr_en` both high is no access. It raises no select, no strobe and no `rd_valid`, and it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| chan_sel | input | CW | Channel index (0 = A, 1 = B) |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| ext_rhr | input | NCH x 8 | Receive holding byte per channel |
| ext_ier | input | NCH x 8 | Interrupt enable byte per channel |
| ext_isr | input | NCH x 8 | Interrupt status byte per channel |
| ext_mcr | input | NCH x 8 | Modem control byte per channel |
| ext_lsr | input | NCH x 8 | Line status byte per channel |
| ext_msr | input | NCH x 8 | Modem status byte per channel |
| chan_en | output | NCH | Per-channel enable |
| reg_sel | output | 17 | One-hot register select of the current access |
| thr_we | output | NCH | Transmit holding write strobe |
| ier_we | output | NCH | Interrupt enable write strobe |
| fcr_we | output | NCH | FIFO control write strobe |
| mcr_we | output | NCH | Modem control write strobe |
| rhr_pop | output | NCH | Receive FIFO pop pulse |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid pulse |
| lcr_o | output | NCH x 8 | Line control byte per channel |
| divisor_o | output | NCH x 16 | Baud divisor per channel |
| efr_o | output | NCH x 8 | Feature byte per channel |
| xon1_o | output | NCH x 8 | First xon character per channel |
| xon2_o | output | NCH x 8 | Second xon character per channel |
| xoff1_o | output | NCH x 8 | First xoff character per channel |
| xoff2_o | output | NCH x 8 | Second xoff character per channel |

## Verification
The channel enable, the register select and the write strobes are combinational, so they are due in the cycle the access is driven. The bench compares them a moment after driving, before the next rising edge, against the model state from before that edge. Read data, its valid pulse and the pop pulse come one edge later. Stored register outputs also change at that edge, so the bench compares all of them at the following falling edge, once its model has applied the access. Because of this split, a select that is one cycle late or a read byte that arrives early shows up as a miscompare.

// File: rtl/dual_uart_regdec_pkg.sv
package dual_uart_regdec_pkg;

    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int NREG = 17;

    typedef enum logic [4:0] {
        REG_RHR, REG_THR, REG_IER, REG_ISR, REG_FCR, REG_LCR,
        REG_MCR, REG_LSR, REG_MSR, REG_SPR, REG_DLL, REG_DLM,
        REG_EFR, REG_XON1, REG_XON2, REG_XOFF1, REG_XOFF2
    } reg_id_e;

    typedef enum logic [1:0] {
        BANK_GEN,
        BANK_DIV,
        BANK_ENH
    } bank_e;

    typedef struct packed {
        logic [DW-1:0] lcr;
        logic [DW-1:0] spr;
        logic [DW-1:0] dll;
        logic [DW-1:0] dlm;
        logic [DW-1:0] efr;
        logic [DW-1:0] xon1;
        logic [DW-1:0] xon2;
        logic [DW-1:0] xoff1;
        logic [DW-1:0] xoff2;
    } chan_regs_t;

endpackage

// File: rtl/udec_chan_sel.sv
module udec_chan_sel #(
    parameter int NCH = 2,
    parameter int CW  = 1
) (
    input  logic           cs_n,
    input  logic [CW-1:0]  chan_sel,
    output logic [NCH-1:0] chan_en,
    output logic           chan_hit
);

    always_comb begin
        chan_en  = '0;
        chan_hit = 1'b0;
        if (!cs_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (chan_sel == CW'(c)) begin
                    chan_en[c] = 1'b1;
                    chan_hit   = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/udec_bank_map.sv
module udec_bank_map
    import dual_uart_regdec_pkg::*;
#(
    parameter logic [DW-1:0] ENH_KEY = 8'hBF
) (
    input  logic            act,
    input  logic            is_wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   lcr,
    output logic [NREG-1:0] sel,
    output reg_id_e         id
);

    bank_e bank;
    logic  hit;

    always_comb begin
        if (lcr == ENH_KEY) begin
            bank = BANK_ENH;
        end else if (lcr[DW-1]) begin
            bank = BANK_DIV;
        end else begin
            bank = BANK_GEN;
        end
    end

    always_comb begin
        hit = 1'b1;
        id  = REG_LCR;
        case (addr)
            3'd0: begin
                if (bank != BANK_GEN) id = REG_DLL;
                else if (is_wr)       id = REG_THR;
                else                  id = REG_RHR;
            end
            3'd1: begin
                if (bank != BANK_GEN) id = REG_DLM;
                else                  id = REG_IER;
            end
            3'd2: begin
                if (bank == BANK_ENH) id = REG_EFR;
                else if (is_wr)       id = REG_FCR;
                else                  id = REG_ISR;
            end
            3'd3: id = REG_LCR;
            3'd4: begin
                if (bank == BANK_ENH) id = REG_XON1;
                else                  id = REG_MCR;
            end
            3'd5: begin
                if (bank == BANK_ENH) begin
                    id = REG_XON2;
                end else begin
                    id  = REG_LSR;
                    hit = !is_wr;
                end
            end
            3'd6: begin
                if (bank == BANK_ENH) begin
                    id = REG_XOFF1;
                end else begin
                    id  = REG_MSR;
                    hit = !is_wr;
                end
            end
            default: begin
                if (bank == BANK_ENH) id = REG_XOFF2;
                else                  id = REG_SPR;
            end
        endcase
        sel = (act && hit) ? (NREG'(1) << id) : '0;
    end

endmodule

// File: rtl/udec_chan_store.sv
module udec_chan_store
    import dual_uart_regdec_pkg::*;
#(
    parameter logic [2*DW-1:0] DIV_RST = 16'h0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] we,
    input  logic [DW-1:0]   wdata,
    output chan_regs_t      regs_o
);

    chan_regs_t regs_d;
    chan_regs_t regs_q;

    logic unused_we;
    assign unused_we = ^{we[REG_RHR], we[REG_THR], we[REG_IER], we[REG_ISR],
                         we[REG_FCR], we[REG_MCR], we[REG_LSR], we[REG_MSR]};

    always_comb begin
        regs_d = regs_q;
        if (we[REG_LCR])   regs_d.lcr   = wdata;
        if (we[REG_SPR])   regs_d.spr   = wdata;
        if (we[REG_DLL])   regs_d.dll   = wdata;
        if (we[REG_DLM])   regs_d.dlm   = wdata;
        if (we[REG_EFR])   regs_d.efr   = wdata;
        if (we[REG_XON1])  regs_d.xon1  = wdata;
        if (we[REG_XON2])  regs_d.xon2  = wdata;
        if (we[REG_XOFF1]) regs_d.xoff1 = wdata;
        if (we[REG_XOFF2]) regs_d.xoff2 = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.dll <= DIV_RST[DW-1:0];
            regs_q.dlm <= DIV_RST[2*DW-1:DW];
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/dual_uart_regdec.sv
module dual_uart_regdec
    import dual_uart_regdec_pkg::*;
#(
    parameter int              NCH     = 2,
    parameter logic [DW-1:0]   ENH_KEY = 8'hBF,
    parameter logic [2*DW-1:0] DIV_RST = 16'h0001,
    localparam int             CW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic [CW-1:0]             chan_sel,
    input  logic [AW-1:0]             addr,
    input  logic                      rd_en,
    input  logic                      wr_en,
    input  logic [DW-1:0]             wdata,
    input  logic [NCH-1:0][DW-1:0]    ext_rhr,
    input  logic [NCH-1:0][DW-1:0]    ext_ier,
    input  logic [NCH-1:0][DW-1:0]    ext_isr,
    input  logic [NCH-1:0][DW-1:0]    ext_mcr,
    input  logic [NCH-1:0][DW-1:0]    ext_lsr,
    input  logic [NCH-1:0][DW-1:0]    ext_msr,
    output logic [NCH-1:0]            chan_en,
    output logic [NREG-1:0]           reg_sel,
    output logic [NCH-1:0]            thr_we,
    output logic [NCH-1:0]            ier_we,
    output logic [NCH-1:0]            fcr_we,
    output logic [NCH-1:0]            mcr_we,
    output logic [NCH-1:0]            rhr_pop,
    output logic [DW-1:0]             rd_data,
    output logic                      rd_valid,
    output logic [NCH-1:0][DW-1:0]    lcr_o,
    output logic [NCH-1:0][2*DW-1:0]  divisor_o,
    output logic [NCH-1:0][DW-1:0]    efr_o,
    output logic [NCH-1:0][DW-1:0]    xon1_o,
    output logic [NCH-1:0][DW-1:0]    xon2_o,
    output logic [NCH-1:0][DW-1:0]    xoff1_o,
    output logic [NCH-1:0][DW-1:0]    xoff2_o
);

    typedef struct packed {
        logic [DW-1:0]  data;
        logic           valid;
        logic [NCH-1:0] pop;
    } rd_out_t;

    logic            chan_hit;
    logic            act;
    logic            is_wr;
    logic [NREG-1:0] sel;
    reg_id_e         id;
    chan_regs_t      regs [NCH];
    chan_regs_t      cur;
    logic [DW-1:0]   cur_rhr, cur_ier, cur_isr, cur_mcr, cur_lsr, cur_msr;
    logic [DW-1:0]   rd_mux;
    rd_out_t         out_d;
    rd_out_t         out_q;

    udec_chan_sel #(
        .NCH (NCH),
        .CW  (CW)
    ) u_chan_sel (
        .cs_n     (cs_n),
        .chan_sel (chan_sel),
        .chan_en  (chan_en),
        .chan_hit (chan_hit)
    );

    assign act   = chan_hit && (rd_en ^ wr_en);
    assign is_wr = wr_en && !rd_en;

    always_comb begin
        cur     = '0;
        cur_rhr = '0;
        cur_ier = '0;
        cur_isr = '0;
        cur_mcr = '0;
        cur_lsr = '0;
        cur_msr = '0;
        for (int c = 0; c < NCH; c++) begin
            if (chan_en[c]) begin
                cur     = regs[c];
                cur_rhr = ext_rhr[c];
                cur_ier = ext_ier[c];
                cur_isr = ext_isr[c];
                cur_mcr = ext_mcr[c];
                cur_lsr = ext_lsr[c];
                cur_msr = ext_msr[c];
            end
        end
    end

    udec_bank_map #(
        .ENH_KEY (ENH_KEY)
    ) u_bank_map (
        .act   (act),
        .is_wr (is_wr),
        .addr  (addr),
        .lcr   (cur.lcr),
        .sel   (sel),
        .id    (id)
    );

    assign reg_sel = sel;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NREG-1:0] we_c;

        assign we_c = (chan_en[c] && is_wr) ? sel : '0;

        udec_chan_store #(
            .DIV_RST (DIV_RST)
        ) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (we_c),
            .wdata  (wdata),
            .regs_o (regs[c])
        );

        assign thr_we[c]    = we_c[REG_THR];
        assign ier_we[c]    = we_c[REG_IER];
        assign fcr_we[c]    = we_c[REG_FCR];
        assign mcr_we[c]    = we_c[REG_MCR];
        assign lcr_o[c]     = regs[c].lcr;
        assign divisor_o[c] = {regs[c].dlm, regs[c].dll};
        assign efr_o[c]     = regs[c].efr;
        assign xon1_o[c]    = regs[c].xon1;
        assign xon2_o[c]    = regs[c].xon2;
        assign xoff1_o[c]   = regs[c].xoff1;
        assign xoff2_o[c]   = regs[c].xoff2;
    end

    always_comb begin
        case (id)
            REG_RHR:   rd_mux = cur_rhr;
            REG_IER:   rd_mux = cur_ier;
            REG_ISR:   rd_mux = cur_isr;
            REG_MCR:   rd_mux = cur_mcr;
            REG_LSR:   rd_mux = cur_lsr;
            REG_MSR:   rd_mux = cur_msr;
            REG_LCR:   rd_mux = cur.lcr;
            REG_SPR:   rd_mux = cur.spr;
            REG_DLL:   rd_mux = cur.dll;
            REG_DLM:   rd_mux = cur.dlm;
            REG_EFR:   rd_mux = cur.efr;
            REG_XON1:  rd_mux = cur.xon1;
            REG_XON2:  rd_mux = cur.xon2;
            REG_XOFF1: rd_mux = cur.xoff1;
            REG_XOFF2: rd_mux = cur.xoff2;
            default:   rd_mux = '0;
        endcase
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        out_d.pop   = '0;
        if (act && !is_wr) begin
            out_d.data  = rd_mux;
            out_d.valid = 1'b1;
            out_d.pop   = sel[REG_RHR] ? chan_en : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data  = out_q.data;
    assign rd_valid = out_q.valid;
    assign rhr_pop  = out_q.pop;

endmodule

// File: rtl/dual_uart_regdec_chk.sv
module dual_uart_regdec_chk
    import dual_uart_regdec_pkg::*;
#(
    parameter int            NCH     = 2,
    parameter logic [DW-1:0] ENH_KEY = 8'hBF,
    parameter int            CW      = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic [CW-1:0]            chan_sel,
    input logic [AW-1:0]            addr,
    input logic                     rd_en,
    input logic                     wr_en,
    input logic [NCH-1:0]           chan_en,
    input logic [NREG-1:0]          reg_sel,
    input logic [NCH-1:0]           thr_we,
    input logic [NCH-1:0]           ier_we,
    input logic [NCH-1:0]           fcr_we,
    input logic [NCH-1:0]           mcr_we,
    input logic [NCH-1:0]           rhr_pop,
    input logic                     rd_valid,
    input logic [NCH-1:0][DW-1:0]   lcr_o,
    input logic [NCH-1:0][2*DW-1:0] divisor_o,
    input logic [NCH-1:0][DW-1:0]   efr_o,
    input logic [NCH-1:0][DW-1:0]   xon1_o,
    input logic [NCH-1:0][DW-1:0]   xon2_o,
    input logic [NCH-1:0][DW-1:0]   xoff1_o,
    input logic [NCH-1:0][DW-1:0]   xoff2_o
);

    logic          in_range;
    logic [DW-1:0] lcr_cur;
    logic          rd_acc;
    logic          ro_write;

    always_comb begin
        in_range = 1'b0;
        lcr_cur  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (chan_sel == CW'(c)) begin
                in_range = 1'b1;
                lcr_cur  = lcr_o[c];
            end
        end
    end

    assign rd_acc   = !cs_n && in_range && rd_en && !wr_en;
    assign ro_write = !cs_n && in_range && wr_en && !rd_en &&
                      (addr == 3'd5 || addr == 3'd6) && lcr_cur != ENH_KEY;

    AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (chan_en == '0 && reg_sel == '0)); // R1

    AST_CHAN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_en)); // R1

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_sel)); // R2

    AST_RO_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        ro_write |=> ($stable(lcr_o) && $stable(divisor_o) && $stable(efr_o) &&
                      $stable(xon1_o) && $stable(xon2_o) &&
                      $stable(xoff1_o) && $stable(xoff2_o))); // R5

    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_valid); // R8

    AST_POP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rhr_pop != '0) |-> (rd_valid && $onehot(rhr_pop))); // R9

    AST_STROBE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_we | ier_we | fcr_we | mcr_we) != '0) |-> (wr_en && !rd_en && !cs_n)); // R10

    AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (reg_sel == '0)); // R11

endmodule

bind dual_uart_regdec dual_uart_regdec_chk #(
    .NCH     (NCH),
    .ENH_KEY (ENH_KEY),
    .CW      (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .chan_sel  (chan_sel),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .chan_en   (chan_en),
    .reg_sel   (reg_sel),
    .thr_we    (thr_we),
    .ier_we    (ier_we),
    .fcr_we    (fcr_we),
    .mcr_we    (mcr_we),
    .rhr_pop   (rhr_pop),
    .rd_valid  (rd_valid),
    .lcr_o     (lcr_o),
    .divisor_o (divisor_o),
    .efr_o     (efr_o),
    .xon1_o    (xon1_o),
    .xon2_o    (xon2_o),
    .xoff1_o   (xoff1_o),
    .xoff2_o   (xoff2_o)
);

// File: tb/dual_uart_regdec_bench.sv
`timescale 1ns/1ps
module dual_uart_regdec_bench;

    localparam int NCH = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cs_n = 1'b1;
    logic [0:0]           chan_sel = '0;
    logic [2:0]           addr = '0;
    logic                 rd_en = 1'b0;
    logic                 wr_en = 1'b0;
    logic [7:0]           wdata = '0;
    logic [1:0][7:0]      ext_rhr = '0, ext_ier = '0, ext_isr = '0;
    logic [1:0][7:0]      ext_mcr = '0, ext_lsr = '0, ext_msr = '0;
    logic [1:0]           chan_en, thr_we, ier_we, fcr_we, mcr_we, rhr_pop;
    logic [16:0]          reg_sel;
    logic [7:0]           rd_data;
    logic                 rd_valid;
    logic [1:0][7:0]      lcr_o, efr_o, xon1_o, xon2_o, xoff1_o, xoff2_o;
    logic [1:0][15:0]     divisor_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    int mreg [NCH][17];
    int exp_rd = 0;

    always #2.5 clk = ~clk;

    dual_uart_regdec u_dual_uart_regdec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .chan_sel(chan_sel), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .ext_rhr(ext_rhr), .ext_ier(ext_ier), .ext_isr(ext_isr),
        .ext_mcr(ext_mcr), .ext_lsr(ext_lsr), .ext_msr(ext_msr),
        .chan_en(chan_en), .reg_sel(reg_sel), .thr_we(thr_we), .ier_we(ier_we),
        .fcr_we(fcr_we), .mcr_we(mcr_we), .rhr_pop(rhr_pop),
        .rd_data(rd_data), .rd_valid(rd_valid), .lcr_o(lcr_o), .divisor_o(divisor_o),
        .efr_o(efr_o), .xon1_o(xon1_o), .xon2_o(xon2_o), .xoff1_o(xoff1_o), .xoff2_o(xoff2_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Register index per the R2/R3/R4 tables; -1 means no register.
    function automatic int exp_idx(input int lcr, input int a, input bit w);
        bit enh = (lcr == 8'hBF);
        bit alt = enh || ((lcr & 8'h80) != 0);
        case (a)
            0: return alt ? 10 : (w ? 1 : 0);
            1: return alt ? 11 : 2;
            2: return enh ? 12 : (w ? 4 : 3);
            3: return 5;
            4: return enh ? 13 : 6;
            5: return enh ? 14 : (w ? -1 : 7);
            6: return enh ? 15 : (w ? -1 : 8);
            default: return enh ? 16 : 9;
        endcase
    endfunction

    function automatic int rdval(input int ch, input int idx);
        case (idx)
            0: return int'(ext_rhr[ch]);
            2: return int'(ext_ier[ch]);
            3: return int'(ext_isr[ch]);
            6: return int'(ext_mcr[ch]);
            7: return int'(ext_lsr[ch]);
            8: return int'(ext_msr[ch]);
            default: return mreg[ch][idx];
        endcase
    endfunction

    task automatic check_store(input string tag);
        for (int c = 0; c < NCH; c++) begin
            chk(tag, $sformatf("lcr[%0d]", c),   int'(lcr_o[c]),     mreg[c][5]);
            chk(tag, $sformatf("div[%0d]", c),   int'(divisor_o[c]), mreg[c][11] * 256 + mreg[c][10]);
            chk(tag, $sformatf("efr[%0d]", c),   int'(efr_o[c]),     mreg[c][12]);
            chk(tag, $sformatf("xon1[%0d]", c),  int'(xon1_o[c]),    mreg[c][13]);
            chk(tag, $sformatf("xon2[%0d]", c),  int'(xon2_o[c]),    mreg[c][14]);
            chk(tag, $sformatf("xoff1[%0d]", c), int'(xoff1_o[c]),   mreg[c][15]);
            chk(tag, $sformatf("xoff2[%0d]", c), int'(xoff2_o[c]),   mreg[c][16]);
        end
    endtask

    // One bus cycle: drive at negedge, compare combinational results, then registered ones.
    task automatic step(input bit cs, input int ch, input int a, input bit r, input bit w,
                        input int d, input string tag);
        bit act;
        int idx;
        int exp_rdv;
        int exp_pop;
        logic [16:0] exp_sel;
        for (int c = 0; c < NCH; c++) begin
            ext_rhr[c] = 8'($urandom); ext_ier[c] = 8'($urandom);
            ext_isr[c] = 8'($urandom); ext_mcr[c] = 8'($urandom);
            ext_lsr[c] = 8'($urandom); ext_msr[c] = 8'($urandom);
        end
        cs_n = cs; chan_sel = 1'(ch); addr = 3'(a); rd_en = r; wr_en = w; wdata = 8'(d);
        #1;
        act = !cs && (r ^ w);
        idx = act ? exp_idx(mreg[ch][5], a, w) : -1;
        exp_sel = (idx >= 0) ? (17'd1 << idx) : 17'd0;
        chk(tag, "chan_en", int'(chan_en), cs ? 0 : (1 << ch));
        chk(tag, "reg_sel", int'(reg_sel), int'(exp_sel));
        chk(tag, "thr_we", int'(thr_we), (act && w && idx == 1) ? (1 << ch) : 0);
        chk(tag, "ier_we", int'(ier_we), (act && w && idx == 2) ? (1 << ch) : 0);
        chk(tag, "fcr_we", int'(fcr_we), (act && w && idx == 4) ? (1 << ch) : 0);
        chk(tag, "mcr_we", int'(mcr_we), (act && w && idx == 6) ? (1 << ch) : 0);
        exp_rdv = 0;
        exp_pop = 0;
        if (act && r) begin
            exp_rdv = 1;
            exp_rd  = rdval(ch, idx);
            exp_pop = (idx == 0) ? (1 << ch) : 0;
        end
        if (act && w && idx >= 0 && (idx == 5 || idx >= 9)) mreg[ch][idx] = d & 8'hFF;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "rd_valid", int'(rd_valid), exp_rdv);
        chk(tag, "rd_data", int'(rd_data), exp_rd);
        chk(tag, "rhr_pop", int'(rhr_pop), exp_pop);
        check_store(tag);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < 17; i++) mreg[c][i] = 0;
            mreg[c][10] = 1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset values
        chk("R7", "rd_data", int'(rd_data), 0);
        chk("R7", "rd_valid", int'(rd_valid), 0);
        check_store("R7");

        // R1: deselected accesses
        step(1, 0, 3, 0, 1, 8'h55, "R1");
        step(1, 1, 0, 1, 0, 0, "R1");
        step(0, 1, 7, 1, 0, 0, "R1");

        // R2/R10: general bank on channel A
        step(0, 0, 0, 0, 1, 8'hA1, "R10");
        step(0, 0, 1, 0, 1, 8'hA2, "R10");
        step(0, 0, 2, 0, 1, 8'hA3, "R10");
        step(0, 0, 4, 0, 1, 8'hA4, "R10");
        step(0, 0, 7, 0, 1, 8'h5A, "R2");
        step(0, 0, 7, 1, 0, 0, "R8");
        step(0, 0, 0, 1, 0, 0, "R9");
        for (int a = 1; a < 8; a++) step(0, 0, a, 1, 0, 0, "R2");

        // R5: writes to read-only addresses
        step(0, 0, 5, 0, 1, 8'hFF, "R5");
        step(0, 0, 6, 0, 1, 8'hFF, "R5");

        // R3: divisor bank
        step(0, 0, 3, 0, 1, 8'h83, "R3");
        step(0, 0, 0, 0, 1, 8'h34, "R3");
        step(0, 0, 1, 0, 1, 8'h12, "R3");
        step(0, 0, 0, 1, 0, 0, "R3");
        step(0, 0, 1, 1, 0, 0, "R3");
        step(0, 0, 2, 1, 0, 0, "R3");
        step(0, 0, 7, 0, 1, 8'h77, "R3");
        step(0, 0, 5, 0, 1, 8'h99, "R5");

        // R6: channel B is still in the general bank
        step(0, 1, 0, 0, 1, 8'hB0, "R6");
        step(0, 1, 7, 0, 1, 8'hB7, "R6");
        step(0, 1, 7, 1, 0, 0, "R6");
        step(0, 1, 0, 1, 0, 0, "R9");

        // R4: enhanced bank on channel A
        step(0, 0, 3, 0, 1, 8'hBF, "R4");
        for (int a = 0; a < 8; a++) if (a != 3) step(0, 0, a, 0, 1, 8'hC0 + a, "R4");
        for (int a = 0; a < 8; a++) step(0, 0, a, 1, 0, 0, "R4");
        step(0, 1, 2, 0, 1, 8'h0F, "R6");
        step(0, 0, 3, 0, 1, 8'h03, "R4");
        step(0, 0, 2, 1, 0, 0, "R4");

        // R11: both strobes
        step(0, 0, 7, 1, 1, 8'hEE, "R11");
        step(0, 1, 3, 1, 1, 8'hBF, "R11");

        // Mixed traffic on both channels
        for (int i = 0; i < 600; i++) begin
            int a = $urandom_range(0, 7);
            int d = $urandom_range(0, 255);
            int k = $urandom_range(0, 9);
            bit w = $urandom_range(0, 1);
            if (a == 3 && w) d = (k < 3) ? 8'hBF : (k < 6) ? 8'h80 : (k < 8) ? 8'h00 : d;
            step($urandom_range(0, 7) == 0, $urandom_range(0, 1), a,
                 $urandom_range(0, 9) == 0 ? 1'b1 : !w, w, d, "R6");
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule